// File: doc/BRIEF.md
# Page-Buffered Write Committer

This block sits between a serial-bus slave front end and a byte-wide storage array. During a write session it collects data bytes in a page-sized staging buffer. At the end of the session it copies them into the array as a single timed internal write cycle. The front end opens a session with an address, delivers bytes one at a time, and closes the session either by committing (on a bus STOP) or by aborting (on a repeated START during write setup). While the internal write cycle runs, the block raises a busy flag, which the front end uses to refuse acknowledges to the bus master.

The upper address bits select the page and are captured when the session opens. The lower bits set the first byte slot. Each loaded byte advances a slot pointer that wraps within the page, so a long burst overwrites bytes loaded earlier in the same session. A per-slot valid mask makes sure that only bytes that were actually loaded reach the array. The write-cycle length is a parameter counted in clock cycles. During the first page-size cycles of the busy interval, the block scans the slots in ascending order and writes each loaded slot.

Top module: `page_wbuf_ctrl`

## Requirements
- R1: After reset busy_o and mem_we_o are low, and no array location is written, so every location still reads 0xFF (erased).
- R2: A start_i outside the busy interval opens a session. It captures the page number from addr_i[12:5] and the first slot from addr_i[4:0].
- R3: Each accepted load_i stores data_i in the current slot and advances the slot by one modulo 32, wrapping to slot 0 of the same page.
- R4: A byte loaded into a slot that already holds a byte from the same session replaces it.
- R5: A commit_i in an open session that has at least one loaded byte raises busy_o on the next cycle and holds it for exactly WR_CYCLES cycles.
- R6: In busy cycle k (k counted from 0, k < 32), mem_we_o is high exactly when slot k was loaded. mem_addr_o is then {page, k} and mem_data_o is the last byte loaded into slot k. No write occurs outside the busy interval.
- R7: A commit_i in a session with no loaded bytes closes the session without raising busy_o or writing.
- R8: abort_i in an open session closes it and discards its bytes. Busy stays low and nothing is written.
- R9: While busy_o is high, start_i, load_i, commit_i and abort_i have no effect.
- R10: In a single cycle: a load_i with commit_i is included in the commit; a load_i with start_i is ignored; abort_i overrides load_i, start_i and commit_i in an open session.
- R11: A start_i in an open session discards the earlier bytes and opens a new session at the new address.
- R12: load_i and commit_i outside an open session are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Open a write session at addr_i |
| addr_i | input | 13 | Start address: page in [12:5], slot in [4:0] |
| load_i | input | 1 | Load data_i into the current slot |
| data_i | input | 8 | Byte to load |
| commit_i | input | 1 | Close the session and write (bus STOP) |
| abort_i | input | 1 | Close the session without writing |
| busy_o | output | 1 | Internal write cycle in progress |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | 13 | Array write address |
| mem_data_o | output | 8 | Array write data |

## Verification
The bench provokes two kinds of same-cycle collision. In the first, the byte load and the session commit arrive together, and the bench judges whether the final byte lands in the array. In the second, an abort arrives with a commit, or a start arrives with a load, and the bench checks that the higher-priority strobe wins. A behavioural model built from queues and associative arrays predicts busy_o and every array write on every cycle. Directed read-backs then compare wrap, overwrite and discard outcomes with hand-computed addresses and values. Strobes sent during the busy interval must leave the array and the busy length unchanged.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_WRITE = 2'd2
  } pwb_state_e;
endpackage

// File: rtl/pwb_page_buf.sv
module pwb_page_buf #(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 32,
  localparam int OFS_W     = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = ADDR_W - OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              open_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [OFS_W-1:0]  rd_slot_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_vld_o,
  output logic              any_vld_o
);
  logic [PAGE_W-1:0]     page_q;
  logic [OFS_W-1:0]      ptr_q;
  logic [PAGE_BYTES-1:0] vld_q;
  logic [DATA_W-1:0]     slot_q [PAGE_BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      ptr_q  <= '0;
    end else if (open_i) begin
      page_q <= addr_i[ADDR_W-1:OFS_W];
      ptr_q  <= addr_i[OFS_W-1:0];
    end else if (ld_i) begin
      ptr_q  <= ptr_q + 1'b1;  // wraps inside page
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic hit;
    assign hit = ld_i && (ptr_q == OFS_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g]  <= 1'b0;
        slot_q[g] <= '0;
      end else begin
        if (open_i)   vld_q[g] <= 1'b0;
        else if (hit) vld_q[g] <= 1'b1;
        if (hit) slot_q[g] <= data_i;
      end
    end
  end

  assign page_o    = page_q;
  assign rd_data_o = slot_q[rd_slot_i];
  assign rd_vld_o  = vld_q[rd_slot_i];
  assign any_vld_o = |vld_q;
endmodule

// File: rtl/pwb_cycle_timer.sv
module pwb_cycle_timer #(
  parameter int WR_CYCLES = 800000,
  localparam int CNT_W    = $clog2(WR_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + 1'b1;
    else            cnt_q <= '0;
  end

  assign cnt_o  = cnt_q;
  assign done_o = run_i && (cnt_q == CNT_W'(WR_CYCLES - 1));
endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic load_i,
  input  logic commit_i,
  input  logic abort_i,
  input  logic any_vld_i,
  input  logic done_i,
  output logic open_o,
  output logic ld_o,
  output logic busy_o
);
  pwb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    open_o  = 1'b0;
    ld_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          open_o  = 1'b1;
          state_d = ST_LOAD;
        end
      end
      ST_LOAD: begin
        if (abort_i) begin
          state_d = ST_IDLE;
        end else if (start_i) begin
          open_o = 1'b1;  // restart, load in same cycle dropped
        end else begin
          ld_o = load_i;
          if (commit_i) state_d = (any_vld_i || load_i) ? ST_WRITE : ST_IDLE;
        end
      end
      ST_WRITE: begin
        if (done_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign busy_o = (state_q == ST_WRITE);
endmodule

// File: rtl/page_wbuf_ctrl.sv
module page_wbuf_ctrl #(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 32,
  parameter int WR_CYCLES  = 800000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              commit_i,
  input  logic              abort_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o
);
  localparam int OFS_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFS_W;
  localparam int CNT_W  = $clog2(WR_CYCLES + 1);

  logic              open_w, ld_w, busy_w, done_w, any_vld_w, rd_vld_w;
  logic [CNT_W-1:0]  cnt_w;
  logic [OFS_W-1:0]  slot_w;
  logic [PAGE_W-1:0] page_w;
  logic [DATA_W-1:0] rd_data_w;
  logic              in_scan_w;

  pwb_ctrl i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .load_i    (load_i),
    .commit_i  (commit_i),
    .abort_i   (abort_i),
    .any_vld_i (any_vld_w),
    .done_i    (done_w),
    .open_o    (open_w),
    .ld_o      (ld_w),
    .busy_o    (busy_w)
  );

  pwb_page_buf #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PAGE_BYTES (PAGE_BYTES)
  ) i_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .open_i    (open_w),
    .addr_i    (addr_i),
    .ld_i      (ld_w),
    .data_i    (data_i),
    .rd_slot_i (slot_w),
    .page_o    (page_w),
    .rd_data_o (rd_data_w),
    .rd_vld_o  (rd_vld_w),
    .any_vld_o (any_vld_w)
  );

  pwb_cycle_timer #(
    .WR_CYCLES (WR_CYCLES)
  ) i_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_w),
    .cnt_o  (cnt_w),
    .done_o (done_w)
  );

  // slot scan occupies the first PAGE_BYTES cycles of the busy interval
  assign slot_w     = cnt_w[OFS_W-1:0];
  assign in_scan_w  = (cnt_w < CNT_W'(PAGE_BYTES));
  assign busy_o     = busy_w;
  assign mem_we_o   = busy_w && in_scan_w && rd_vld_w;
  assign mem_addr_o = {page_w, slot_w};
  assign mem_data_o = rd_data_w;
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int ADDR_W    = 13,
  parameter int OFS_W     = 5,
  parameter int WR_CYCLES = 800000,
  localparam int LEN_W    = $clog2(WR_CYCLES + 1) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              commit_i,
  input logic              abort_i,
  input logic              busy_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     len_q <= '0;
    else if (busy_o) len_q <= len_q + 1'b1;
    else             len_q <= '0;
  end

  // R5
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (len_q == LEN_W'(WR_CYCLES)));
  // R5
  busy_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (len_q < LEN_W'(WR_CYCLES)));
  // R6
  we_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);
  // R6
  page_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(mem_addr_o[ADDR_W-1:OFS_W]));
  // R7
  busy_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(commit_i) && !$past(abort_i)));
  // R8
  abort_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && !busy_o) |=> !busy_o);
endmodule

bind page_wbuf_ctrl pwb_checker #(
  .ADDR_W    (ADDR_W),
  .OFS_W     ($clog2(PAGE_BYTES)),
  .WR_CYCLES (WR_CYCLES)
) i_pwb_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .commit_i   (commit_i),
  .abort_i    (abort_i),
  .busy_o     (busy_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o)
);

// File: tb/test_page_wbuf_ctrl.sv
`timescale 1ns/1ps
module test_page_wbuf_ctrl;
  localparam int WR = 40;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, load_i = 1'b0, commit_i = 1'b0, abort_i = 1'b0;
  logic [12:0] addr_i = '0;
  logic [7:0]  data_i = '0;
  logic        busy_o, mem_we_o;
  logic [12:0] mem_addr_o;
  logic [7:0]  mem_data_o;

  int tests = 0;
  int fails = 0;
  bit done_flag = 1'b0;

  always #2.5 clk_i = ~clk_i;

  page_wbuf_ctrl #(.WR_CYCLES(WR)) i_page_wbuf_ctrl (
    .clk_i, .rst_ni, .start_i, .addr_i, .load_i, .data_i,
    .commit_i, .abort_i, .busy_o, .mem_we_o, .mem_addr_o, .mem_data_o
  );

  // harness array, erased content is 0xFF
  byte unsigned hmem [int];
  byte unsigned refmem [int];
  always @(posedge clk_i) if (rst_ni && mem_we_o) hmem[int'(mem_addr_o)] = mem_data_o;

  function automatic byte unsigned rd_h(int a);
    return hmem.exists(a) ? hmem[a] : 8'hFF;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_mem(int a, int exp, string req);
    check(rd_h(a) == exp, req, $sformatf("array[0x%0h]", a), rd_h(a), exp);
  endtask

  // behavioural reference model
  bit m_busy = 0, m_sess = 0;
  int m_k = 0, m_page = 0, m_ptr = 0;
  byte unsigned m_buf [int];

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_busy = 0; m_sess = 0; m_k = 0; m_buf.delete();
    end else if (m_busy) begin
      m_k++;
      if (m_k == WR) m_busy = 0;
    end else if (m_sess && abort_i) begin
      m_sess = 0;
    end else if (start_i) begin
      m_sess = 1; m_page = int'(addr_i) / 32; m_ptr = int'(addr_i) % 32; m_buf.delete();
    end else if (m_sess) begin
      if (load_i) begin
        m_buf[m_ptr] = data_i;
        m_ptr = (m_ptr + 1) % 32;
      end
      if (commit_i) begin
        m_sess = 0;
        if (m_buf.num() > 0) begin m_busy = 1; m_k = 0; end
      end
    end
  end

  int blen = 0;
  always @(negedge clk_i) begin
    if (rst_ni && !done_flag) begin
      bit ew;
      ew = m_busy && m_k < 32 && m_buf.exists(m_k);
      check(busy_o == m_busy, "R5", "busy_o per cycle", busy_o, m_busy);
      check(mem_we_o == ew, "R6", "mem_we_o per cycle", mem_we_o, ew);
      if (ew && mem_we_o) begin
        check(int'(mem_addr_o) == m_page * 32 + m_k, "R6", "mem_addr_o", mem_addr_o, m_page * 32 + m_k);
        check(mem_data_o == m_buf[m_k], "R6", "mem_data_o", mem_data_o, m_buf[m_k]);
        refmem[m_page * 32 + m_k] = m_buf[m_k];
      end
      if (busy_o) blen++;
      else if (blen != 0) begin
        check(blen == WR, "R5", "busy length", blen, WR);
        blen = 0;
      end
    end
  end

  task automatic drv(bit s, int a, bit l, int d, bit c, bit ab);
    @(negedge clk_i);
    start_i = s; addr_i = 13'(a); load_i = l; data_i = 8'(d); commit_i = c; abort_i = ab;
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) drv(0, 0, 0, 0, 0, 0);
  endtask
  task automatic wait_idle();
    idle(1);
    while (busy_o) @(negedge clk_i);
    idle(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check(busy_o == 0, "R1", "busy_o after reset", busy_o, 0);
    check(mem_we_o == 0, "R1", "mem_we_o after reset", mem_we_o, 0);
    chk_mem(13'h0123, 8'hFF, "R1");

    // R2 single byte, page and slot from address
    drv(1, 13'h0123, 0, 0, 0, 0);
    drv(0, 0, 1, 8'hA5, 0, 0);
    drv(0, 0, 0, 0, 1, 0);
    wait_idle();
    chk_mem(13'h0123, 8'hA5, "R2");
    chk_mem(13'h0124, 8'hFF, "R6");

    // R3 wrap inside page from slot 30
    drv(1, 13'h1FFE, 0, 0, 0, 0);
    drv(0, 0, 1, 8'h11, 0, 0);
    drv(0, 0, 1, 8'h22, 0, 0);
    drv(0, 0, 1, 8'h33, 0, 0);
    drv(0, 0, 1, 8'h44, 0, 0);
    drv(0, 0, 0, 0, 1, 0);
    wait_idle();
    chk_mem(13'h1FFF, 8'h22, "R3");
    chk_mem(13'h1FE0, 8'h33, "R3");
    chk_mem(13'h1FE1, 8'h44, "R3");
    chk_mem(13'h0000, 8'hFF, "R3");

    // R4 34 bytes from slot 5 overwrite slots 5 and 6
    drv(1, 13'h0045, 0, 0, 0, 0);
    for (int i = 0; i < 34; i++) drv(0, 0, 1, 8'h80 + i, 0, 0);
    drv(0, 0, 0, 0, 1, 0);
    wait_idle();
    chk_mem(13'h0045, 8'hA0, "R4");
    chk_mem(13'h0046, 8'hA1, "R4");
    chk_mem(13'h0047, 8'h82, "R4");
    chk_mem(13'h0044, 8'h9F, "R4");

    // R7 address-only session
    drv(1, 13'h0200, 0, 0, 0, 0);
    drv(0, 0, 0, 0, 1, 0);
    idle(3);
    check(busy_o == 0, "R7", "busy_o after empty commit", busy_o, 0);

    // R8 abort, then R12 stray commit
    drv(1, 13'h0300, 0, 0, 0, 0);
    drv(0, 0, 1, 8'h55, 0, 0);
    drv(0, 0, 0, 0, 0, 1);
    drv(0, 0, 0, 0, 1, 0);
    idle(3);
    check(busy_o == 0, "R12", "busy_o after stray commit", busy_o, 0);
    chk_mem(13'h0300, 8'hFF, "R8");

    // R11 restart drops earlier bytes
    drv(1, 13'h0400, 0, 0, 0, 0);
    drv(0, 0, 1, 8'h01, 0, 0);
    drv(1, 13'h0500, 0, 0, 0, 0);
    drv(0, 0, 1, 8'h02, 0, 0);
    drv(0, 0, 0, 0, 1, 0);
    wait_idle();
    chk_mem(13'h0400, 8'hFF, "R11");
    chk_mem(13'h0500, 8'h02, "R11");

    // R9 strobes during busy
    drv(1, 13'h0600, 0, 0, 0, 0);
    drv(0, 0, 1, 8'h66, 0, 0);
    drv(0, 0, 0, 0, 1, 0);
    drv(1, 13'h0700, 0, 0, 0, 0);
    drv(0, 0, 1, 8'h77, 0, 0);
    drv(0, 0, 0, 0, 1, 0);
    drv(0, 0, 0, 0, 0, 1);
    wait_idle();
    idle(2);
    check(busy_o == 0, "R9", "busy_o after ignored commit", busy_o, 0);
    chk_mem(13'h0600, 8'h66, "R9");
    chk_mem(13'h0700, 8'hFF, "R9");

    // R10 load with commit
    drv(1, 13'h0800, 0, 0, 0, 0);
    drv(0, 0, 1, 8'h11, 0, 0);
    drv(0, 0, 1, 8'h22, 1, 0);
    wait_idle();
    chk_mem(13'h0801, 8'h22, "R10");
    // R10 load with start is dropped
    drv(1, 13'h0900, 1, 8'h99, 0, 0);
    drv(0, 0, 1, 8'h9A, 0, 0);
    drv(0, 0, 0, 0, 1, 0);
    wait_idle();
    chk_mem(13'h0900, 8'h9A, "R10");
    chk_mem(13'h0901, 8'hFF, "R10");
    // R10 abort beats commit
    drv(1, 13'h0A00, 0, 0, 0, 0);
    drv(0, 0, 1, 8'hAA, 0, 0);
    drv(0, 0, 1, 8'hAB, 1, 1);
    idle(3);
    check(busy_o == 0, "R10", "busy_o after abort+commit", busy_o, 0);
    chk_mem(13'h0A00, 8'hFF, "R10");

    // R12 load and commit outside a session
    drv(0, 0, 1, 8'h33, 0, 0);
    drv(0, 0, 0, 0, 1, 0);
    idle(3);
    check(busy_o == 0, "R12", "busy_o after idle load/commit", busy_o, 0);

    // R6 full array agreement with model
    foreach (refmem[a]) chk_mem(a, refmem[a], "R6");
    check(hmem.num() == refmem.num(), "R6", "written location count", hmem.num(), refmem.num());

    done_flag = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule